// File: doc/BRIEF.md
# Framed Serial DAC Input Controller

This block is the digital front end of a 16-bit serial-input voltage DAC. A host drives three wires: an active-low frame select, a serial clock and a serial data line. The block oversamples them with a faster system clock, collects a 24-bit word, and checks that the word is complete. Only a complete word changes the converter code and the power-down mode.

A frame starts when the frame select falls. One data bit is taken on each falling edge of the serial clock, most significant bit first. The frame takes effect on exactly the 24th falling edge. If the frame select rises before that edge, the partial word is dropped. Once 24 bits are in, further clock edges are ignored until the frame select rises again.

The data field arrives in two's complement. It is turned into the offset-binary code that the resistor core expects. After reset the core sits at midscale until the first valid write completes. The serial clock may run at up to a quarter of the system clock rate.

Top module: `sdac_front`

## Requirements
- R1: While reset is held and after it is released, `core_code` is 0x8000 (midscale), `pd_mode` is 0 and `upd_stb` is low until the first complete frame.
- R2: A frame carries 24 bits, most significant first, each sampled at a falling edge of `ser_clk` while `frame_n` is low. Bits [15:0] are the data word and bits [17:16] are the power-down mode.
- R3: A frame takes effect only on its 24th falling edge. `core_code` and `pd_mode` change in the same cycle as a one-cycle `upd_stb` pulse, and at no other time.
- R4: If `frame_n` rises before the 24th falling edge, the frame is dropped: no strobe, and `core_code` and `pd_mode` keep their values.
- R5: Falling edges after the 24th and before `frame_n` rises are ignored. The frame commits once, with the first 24 bits.
- R6: Frame bits [23:18] have no effect on the outputs.
- R7: The data word is two's complement. `core_code` equals the data word with bit 15 inverted: 0x7FFF gives 0xFFFF, 0x8000 gives 0x0000, and 0xFFFF gives 0x7FFF.
- R8: The bit count clears whenever `frame_n` is high. A full frame sent after a dropped frame commits correctly.
- R9: Every commit loads `pd_mode` from the frame, including a return from a nonzero mode to 0 (normal operation).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_n | input | 1 | Active-low frame select, asynchronous to `clk` |
| ser_clk | input | 1 | Serial clock; data is taken on its falling edge |
| ser_data | input | 1 | Serial data, most significant bit first |
| core_code | output | 16 | Offset-binary code for the converter core |
| pd_mode | output | 2 | Power-down mode field, 0 = normal operation |
| upd_stb | output | 1 | One-cycle pulse when a frame commits |

## Verification
The bench builds the block with its default parameters: a 24-bit frame, a 16-bit code, a 2-bit mode and two synchroniser stages. It runs the serial clock at one eighth of the system clock. That rate leaves the full synchroniser and edge-detect latency inside each half period.

Because of this frame size, a frame can be dropped after 23 bits, one bit short of the commit edge. Four extra edges can also follow the 24th. The code conversion can be driven to both ends of the two's-complement range and across the sign boundary.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int DEF_FRAME_BITS = 24;
  localparam int DEF_CODE_W     = 16;
  localparam int DEF_MODE_W     = 2;
  localparam int DEF_SYNC_STG   = 2;

  typedef enum logic [1:0] {
    PD_ACTIVE = 2'd0,
    PD_LOW_Z  = 2'd1,
    PD_MID_Z  = 2'd2,
    PD_HIGH_Z = 2'd3
  } pd_mode_e;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[0] <= RST_VAL;
          else        stage_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= RST_VAL;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/sdac_framer.sv
module sdac_framer #(
  parameter int FRAME_BITS = 24,
  parameter int KEEP_BITS  = 18,
  localparam int CNT_W     = $clog2(FRAME_BITS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sel_n_s,
  input  logic                 sclk_s,
  input  logic                 sdat_s,
  output logic [KEEP_BITS-1:0] word_q,
  output logic                 done_q
);
  logic             sel_prev, sclk_prev;
  logic [CNT_W-1:0] cnt_q;
  logic             sclk_fall, sel_rise, frame_full, take_bit;

  assign sclk_fall  = sclk_prev & ~sclk_s;
  assign sel_rise   = sel_n_s & ~sel_prev;
  assign frame_full = (cnt_q == CNT_W'(FRAME_BITS));
  assign take_bit   = sclk_fall & ~sel_n_s & ~frame_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_prev  <= 1'b1;
      sclk_prev <= 1'b1;
    end else begin
      sel_prev  <= sel_n_s;
      sclk_prev <= sclk_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      word_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (sel_n_s) begin
        cnt_q <= '0;
      end else if (take_bit) begin
        word_q <= {word_q[KEEP_BITS-2:0], sdat_s};
        cnt_q  <= cnt_q + 1'b1;
        done_q <= (cnt_q == CNT_W'(FRAME_BITS - 1));
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(FRAME_BITS)); // R5
  AST_DONE_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> frame_full); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R3
  AST_RISE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    sel_rise |=> (cnt_q == '0)); // R8
  AST_FULL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_full && !sel_n_s) |=> $stable(word_q)); // R5
endmodule

// File: rtl/sdac_regs.sv
module sdac_regs #(
  parameter int CODE_W    = 16,
  parameter int MODE_W    = 2,
  localparam int KEEP_BITS = CODE_W + MODE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [KEEP_BITS-1:0] word_in,
  input  logic                 commit,
  output logic [CODE_W-1:0]    core_code,
  output logic [MODE_W-1:0]    pd_mode,
  output logic                 upd_stb
);
  localparam logic [CODE_W-1:0] SIGN_MASK = {1'b1, {(CODE_W-1){1'b0}}};

  function automatic logic [CODE_W-1:0] twos_to_offset(input logic [CODE_W-1:0] d);
    return d ^ SIGN_MASK;
  endfunction

  logic [CODE_W-1:0] data_f;
  logic [MODE_W-1:0] mode_f;

  assign data_f = word_in[CODE_W-1:0];
  assign mode_f = word_in[KEEP_BITS-1:CODE_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_code <= twos_to_offset('0);
      pd_mode   <= '0;
      upd_stb   <= 1'b0;
    end else begin
      upd_stb <= commit;
      if (commit) begin
        core_code <= twos_to_offset(data_f);
        pd_mode   <= mode_f;
      end
    end
  end

  AST_STB_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> upd_stb); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_stb |-> ($stable(core_code) && $stable(pd_mode))); // R4
  AST_STB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |=> !upd_stb); // R3
endmodule

// File: rtl/sdac_front.sv
module sdac_front #(
  parameter int FRAME_BITS = sdac_pkg::DEF_FRAME_BITS,
  parameter int CODE_W     = sdac_pkg::DEF_CODE_W,
  parameter int MODE_W     = sdac_pkg::DEF_MODE_W,
  parameter int SYNC_STG   = sdac_pkg::DEF_SYNC_STG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic              ser_clk,
  input  logic              ser_data,
  output logic [CODE_W-1:0] core_code,
  output logic [MODE_W-1:0] pd_mode,
  output logic              upd_stb
);
  localparam int KEEP_BITS = CODE_W + MODE_W;

  logic [2:0]           pins_s;
  logic [KEEP_BITS-1:0] word_w;
  logic                 done_w;

  sdac_sync #(.W(3), .STAGES(SYNC_STG), .RST_VAL(3'b110)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({frame_n, ser_clk, ser_data}),
    .sync_out (pins_s)
  );

  sdac_framer #(.FRAME_BITS(FRAME_BITS), .KEEP_BITS(KEEP_BITS)) u_framer (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel_n_s (pins_s[2]),
    .sclk_s  (pins_s[1]),
    .sdat_s  (pins_s[0]),
    .word_q  (word_w),
    .done_q  (done_w)
  );

  sdac_regs #(.CODE_W(CODE_W), .MODE_W(MODE_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_in   (word_w),
    .commit    (done_w),
    .core_code (core_code),
    .pd_mode   (pd_mode),
    .upd_stb   (upd_stb)
  );

  AST_RESET_MID: assert property (@(posedge clk)
    !rst_n |=> (core_code == {1'b1, {(CODE_W-1){1'b0}}} || rst_n)); // R1
endmodule

// File: tb/sdac_front_test.sv
module sdac_front_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1;
  logic        ser_clk = 1'b1;
  logic        ser_data = 1'b0;
  logic [15:0] core_code;
  logic [1:0]  pd_mode;
  logic        upd_stb;

  int n_chk = 0;
  int n_bad = 0;
  logic [17:0] exp_q[$];
  logic [15:0] cur_code = 16'h8000;
  logic [1:0]  cur_mode = 2'd0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  sdac_front uut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .ser_clk(ser_clk),
    .ser_data(ser_data), .core_code(core_code), .pd_mode(pd_mode),
    .upd_stb(upd_stb)
  );

  function automatic logic [15:0] offset_of(input logic [15:0] d);
    return 16'((32'(d) + 32'd32768) % 32'd65536); // R7
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // drive nbits of word (MSB first), optionally commit-expected
  task automatic send(input logic [23:0] w, input int nbits);
    if (nbits >= 24) exp_q.push_back({w[17:16], offset_of(w[15:0])});
    @(negedge clk);
    frame_n = 1'b0;
    idle(4);
    for (int i = 0; i < nbits; i++) begin
      ser_data = (i < 24) ? w[23-i] : ~w[0];
      ser_clk  = 1'b1;
      idle(4);
      ser_clk = 1'b0;
      idle(4);
      ser_clk = 1'b1;
    end
    idle(4);
    frame_n = 1'b1;
    idle(8);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !done && upd_stb) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R4 unexpected strobe", {14'd0, pd_mode, core_code}, 32'd0);
      end else begin
        logic [17:0] e;
        e = exp_q.pop_front();
        check({pd_mode, core_code} == e, "R2/R3/R7 commit value",
              {14'd0, pd_mode, core_code}, {14'd0, e});
        cur_code = e[15:0];
        cur_mode = e[17:16];
      end
    end
  end

  task automatic check_hold(input string req);
    check(core_code == cur_code && pd_mode == cur_mode && !upd_stb, req,
          {15'd0, upd_stb, pd_mode, core_code}, {16'd0, cur_mode, cur_code});
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", wd);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    idle(3);
    check(core_code == 16'h8000 && pd_mode == 0 && !upd_stb, "R1 in reset",
          {14'd0, pd_mode, core_code}, 32'h8000);
    rst_n = 1'b1;
    idle(10);
    check_hold("R1 after reset");

    send(24'h00_1234, 24);                    // R2 R7 basic
    send(24'h00_7FFF, 24);                    // R7 max positive
    send(24'h00_8000, 24);                    // R7 most negative
    send(24'h00_FFFF, 24);                    // R7 minus one
    send(24'h02_0005, 24);                    // R9 mode 2
    send(24'h03_4321, 10);                    // R4 short abort
    check_hold("R4 abort at 10 bits");
    send(24'h01_AAAA, 23);                    // R4 abort one short
    check_hold("R4 abort at 23 bits");
    send(24'h01_5A5A, 24);                    // R8 full after abort
    check(cur_code == 16'hDA5A && cur_mode == 2'd1, "R8 frame after abort",
          {14'd0, cur_mode, cur_code}, 32'h1DA5A);
    send(24'hFC_0000, 24);                    // R6 high bits set, R9 back to 0
    check(cur_code == 16'h8000 && cur_mode == 2'd0, "R6/R9 ignored bits, mode 0",
          {14'd0, cur_mode, cur_code}, 32'h08000);
    send(24'h03_C3C3, 28);                    // R5 extra edges
    check(cur_code == 16'h43C3 && cur_mode == 2'd3, "R5 extra edges ignored",
          {14'd0, cur_mode, cur_code}, 32'h343C3);
    idle(20);
    check_hold("R3 no strobe when idle");
    check(exp_q.size() == 0, "R3 all commits seen", exp_q.size(), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule